// File: doc/BRIEF.md
# Dual-Rounding Integer Divider

This unit divides one integer by another and returns both a quotient and a remainder. Each operation can treat its operands as two's-complement signed or as unsigned values. It can round in one of two ways: toward zero, which is what the HDL `/` and `%` operators do, or toward negative infinity, which gives a modulo result with the sign of the divisor.

Internally the unit works on magnitudes. It runs an unsigned restoring divider that takes one bit per clock. It then restores the signs and, when flooring is selected, adjusts the truncated result.

A caller waits for `ready`, then pulses `start` together with the operands, the signedness flag and the rounding mode. The unit holds exactly one operation at a time. A zero divisor does not produce an undefined value: the unit raises a flag and drives fixed output values.

Top module: `divmod_unit`

## Requirements
- R1: With `mode`=0 (truncate), `quotient` equals the dividend divided by the divisor rounded toward zero, for both signed and unsigned operands.
- R2: With `mode`=0, `remainder` equals dividend − quotient·divisor, so a nonzero remainder has the sign of the dividend and a smaller magnitude than the divisor.
- R3: With `mode`=1 (floor) and `signed_op`=1, `quotient` is the quotient rounded toward negative infinity. It is one less than the truncated quotient whenever the truncated remainder is nonzero and its sign differs from the divisor's sign.
- R4: With `mode`=1 and `signed_op`=1, `remainder` equals dividend − quotient·divisor, so a nonzero remainder has the sign of the divisor.
- R5: With `signed_op`=0, both operands are unsigned, and the two modes give identical results.
- R6: When the divisor is zero, in either mode and either signedness, `div_zero` is 1, `quotient` is all ones and `remainder` equals the dividend. Otherwise `div_zero` is 0.
- R7: For a signed operation with the most negative dividend and a divisor of −1, `quotient` is the most negative value, `remainder` is 0 and `div_zero` is 0, in both modes.
- R8: A `start` sampled at a rising edge while `ready` is 1 begins an operation. `done` is 1 for exactly one cycle, following the (WIDTH+1)-th rising edge after the accepting edge. `ready` is 0 from the accepting edge until `done` is raised.
- R9: While the unit is busy, `start` is ignored: it produces no extra `done` and does not change the operation in flight. `quotient`, `remainder` and `div_zero` hold their values until the next operation completes.
- R10: Synchronous active-high `rst` clears `quotient`, `remainder`, `div_zero` and `done` to 0 and leaves `ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin an operation; taken only while `ready` is 1 |
| signed_op | input | 1 | 1: operands are two's complement; 0: operands are unsigned |
| mode | input | 1 | 0: truncate toward zero; 1: floor toward negative infinity |
| dividend | input | WIDTH | Dividend |
| divisor | input | WIDTH | Divisor |
| ready | output | 1 | Unit is idle and accepts `start` |
| done | output | 1 | One-cycle pulse when results are valid |
| quotient | output | WIDTH | Quotient result |
| remainder | output | WIDTH | Remainder or modulo result |
| div_zero | output | 1 | Divisor was zero |

## Verification
The hardest condition to reach from the ports is a `start` pulse that arrives while an operation is already in flight and carries different operands. If the unit wrongly accepted it, the only signs would be an extra `done` or a corrupted result. To create this case, the stimulus issues a second pulse a few cycles into every directed operation and checks that `ready` is low at that moment. The scoreboard then flags any `done` that has no matching queued operation. The floor adjustment and the wrap of the most negative dividend divided by −1 only show up for particular sign combinations, so directed pairs covering all four sign quadrants precede a long run of random operands in both modes and both signednesses.

// File: rtl/divmod_pkg.sv
package divmod_pkg;

    typedef enum logic {
        RND_TRUNC = 1'b0,
        RND_FLOOR = 1'b1
    } rnd_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    function automatic int unsigned step_cnt_bits(input int unsigned steps);
        return $clog2(steps + 1);
    endfunction

endpackage

// File: rtl/div_prep.sv
module div_prep #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] dvd_raw,
    input  logic [W-1:0] dvs_raw,
    input  logic         is_signed,
    output logic [W-1:0] dvd_mag,
    output logic [W-1:0] dvs_mag,
    output logic         dvd_neg,
    output logic         dvs_neg
);
    always_comb begin
        dvd_neg = is_signed & dvd_raw[W-1];
        dvs_neg = is_signed & dvs_raw[W-1];
        dvd_mag = dvd_neg ? (~dvd_raw + 1'b1) : dvd_raw;
        dvs_mag = dvs_neg ? (~dvs_raw + 1'b1) : dvs_raw;
    end
endmodule

// File: rtl/div_core.sv
module div_core
    import divmod_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] dvd_mag,
    input  logic [W-1:0] dvs_mag,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quo_mag,
    output logic [W-1:0] rem_mag
);
    localparam int unsigned CW = step_cnt_bits(W);

    seq_state_e   state;
    logic [CW-1:0] steps_left;
    logic [W-1:0]  q_r, r_r, d_r;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic [W-1:0]  q_nx, r_nx;

    always_comb begin
        trial = {r_r, q_r[W-1]};
        diff  = trial - {1'b0, d_r};
        if (!diff[W]) begin
            r_nx = diff[W-1:0];
            q_nx = {q_r[W-2:0], 1'b1};
        end else begin
            r_nx = trial[W-1:0];
            q_nx = {q_r[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            steps_left <= '0;
            q_r        <= '0;
            r_r        <= '0;
            d_r        <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (load) begin
                    q_r        <= dvd_mag;
                    r_r        <= '0;
                    d_r        <= dvs_mag;
                    steps_left <= CW'(W);
                    state      <= SEQ_RUN;
                end
                SEQ_RUN: begin
                    q_r        <= q_nx;
                    r_r        <= r_nx;
                    steps_left <= steps_left - 1'b1;
                    if (steps_left == CW'(1)) state <= SEQ_FIN;
                end
                SEQ_FIN:  state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy    = (state != SEQ_IDLE);
    assign fin     = (state == SEQ_FIN);
    assign quo_mag = q_r;
    assign rem_mag = r_r;

    // R2
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (rst)
        (fin && d_r != '0) |-> (r_r < d_r));

    // R8
    fin_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        fin |-> $past(state == SEQ_RUN));
endmodule

// File: rtl/div_fixup.sv
module div_fixup
    import divmod_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic [W-1:0] dvd_raw,
    input  logic [W-1:0] dvs_raw,
    input  logic         dvd_neg,
    input  logic         dvs_neg,
    input  logic         is_signed,
    input  rnd_mode_e    rnd,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out,
    output logic         zero_div
);
    logic [W-1:0] q_tr, r_tr;
    logic         adjust;

    always_comb begin
        q_tr     = (dvd_neg ^ dvs_neg) ? (~quo_mag + 1'b1) : quo_mag;
        r_tr     = dvd_neg ? (~rem_mag + 1'b1) : rem_mag;
        adjust   = (rnd == RND_FLOOR) && is_signed && (r_tr != '0)
                   && (r_tr[W-1] != dvs_raw[W-1]);
        zero_div = (dvs_raw == '0);
        if (zero_div) begin
            quo_out = '1;
            rem_out = dvd_raw;
        end else if (adjust) begin
            quo_out = q_tr - 1'b1;
            rem_out = r_tr + dvs_raw;
        end else begin
            quo_out = q_tr;
            rem_out = r_tr;
        end
    end
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
    import divmod_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             signed_op,
    input  logic             mode,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             ready,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             div_zero
);
    logic [WIDTH-1:0] in_dvd_mag, in_dvs_mag;
    logic             in_dvd_neg, in_dvs_neg;
    logic [WIDTH-1:0] a_q, b_q;
    logic             na_q, nb_q, s_q;
    rnd_mode_e        m_q;
    logic             core_busy, core_fin, accept;
    logic [WIDTH-1:0] qm, rm, fx_quo, fx_rem;
    logic             fx_zero;

    assign ready  = ~core_busy;
    assign accept = start & ready;

    div_prep #(.W(WIDTH)) u_prep (
        .dvd_raw(dividend), .dvs_raw(divisor), .is_signed(signed_op),
        .dvd_mag(in_dvd_mag), .dvs_mag(in_dvs_mag),
        .dvd_neg(in_dvd_neg), .dvs_neg(in_dvs_neg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            b_q  <= '0;
            na_q <= 1'b0;
            nb_q <= 1'b0;
            s_q  <= 1'b0;
            m_q  <= RND_TRUNC;
        end else if (accept) begin
            a_q  <= dividend;
            b_q  <= divisor;
            na_q <= in_dvd_neg;
            nb_q <= in_dvs_neg;
            s_q  <= signed_op;
            m_q  <= rnd_mode_e'(mode);
        end
    end

    div_core #(.W(WIDTH)) u_core (
        .clk(clk), .rst(rst), .load(accept),
        .dvd_mag(in_dvd_mag), .dvs_mag(in_dvs_mag),
        .busy(core_busy), .fin(core_fin),
        .quo_mag(qm), .rem_mag(rm)
    );

    div_fixup #(.W(WIDTH)) u_fix (
        .quo_mag(qm), .rem_mag(rm), .dvd_raw(a_q), .dvs_raw(b_q),
        .dvd_neg(na_q), .dvs_neg(nb_q), .is_signed(s_q), .rnd(m_q),
        .quo_out(fx_quo), .rem_out(fx_rem), .zero_div(fx_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            quotient  <= '0;
            remainder <= '0;
            div_zero  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= core_fin;
            if (core_fin) begin
                quotient  <= fx_quo;
                remainder <= fx_rem;
                div_zero  <= fx_zero;
            end
        end
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !core_fin |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

    // R2
    trunc_rem_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (done && m_q == RND_TRUNC && s_q && !div_zero && remainder != '0)
        |-> (remainder[WIDTH-1] == a_q[WIDTH-1]));

    // R4
    floor_rem_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (done && m_q == RND_FLOOR && s_q && !div_zero && remainder != '0)
        |-> (remainder[WIDTH-1] == b_q[WIDTH-1]));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done && div_zero) |-> (quotient == '1 && remainder == a_q && b_q == '0));
endmodule

// File: tb/tb_divmod_unit.sv
module tb_divmod_unit;
    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         signed_op = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         ready, done, div_zero;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    logic finished = 1'b0;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         z;
        longint       issue;
        string        tag;
    } exp_t;

    exp_t sb[$];
    logic [W-1:0] last_q, last_r;
    logic         last_z;

    divmod_unit #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .start(start), .signed_op(signed_op), .mode(mode),
        .dividend(dividend), .divisor(divisor), .ready(ready), .done(done),
        .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input bit s, input bit m);
        exp_t e;
        longint la, lb, qq, rr;
        if (b == '0) begin
            e.q = '1; e.r = a; e.z = 1'b1; e.tag = "R6";
            return e;
        end
        la = s ? longint'($signed(a)) : longint'(a);
        lb = s ? longint'($signed(b)) : longint'(b);
        qq = la / lb;
        rr = la % lb;
        if (m && rr != 0 && ((rr < 0) != (lb < 0))) begin
            qq = qq - 1;
            rr = rr + lb;
        end
        e.q = qq[W-1:0]; e.r = rr[W-1:0]; e.z = 1'b0;
        if (s && a == {1'b1, {(W-1){1'b0}}} && b == '1) e.tag = "R7";
        else if (!s) e.tag = "R5";
        else if (m) e.tag = "R3/R4";
        else e.tag = "R1/R2";
        return e;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "done with no operation queued", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quotient == e.q, e.tag, "quotient", quotient, e.q);
                check(remainder == e.r, e.tag, "remainder", remainder, e.r);
                check(div_zero == e.z, e.tag, "div_zero", div_zero, e.z);
                // R8 latency
                check(cyc == e.issue + W + 1, "R8", "done cycle", cyc, e.issue + W + 1);
                last_q = e.q; last_r = e.r; last_z = e.z;
            end
        end
    end

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit s, input bit m, input bit poke);
        exp_t e;
        @(negedge clk);
        while (!ready) @(negedge clk);
        e = model(a, b, s, m);
        e.issue = cyc + 1;
        sb.push_back(e);
        dividend = a; divisor = b; signed_op = s; mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            // R8: busy means not ready
            check(ready == 1'b0, "R8", "ready while busy", ready, 0);
            // R9: start while busy must be ignored
            dividend = ~a; divisor = b + 16'd3; signed_op = ~s; mode = ~m; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        do @(negedge clk); while (sb.size() != 0);
        if (poke) begin
            repeat (4) @(negedge clk);
            // R9: outputs hold, no extra done
            check(quotient == last_q && remainder == last_r && div_zero == last_z,
                  "R9", "held result", {quotient, remainder}, {last_q, last_r});
            check(done == 1'b0 && sb.size() == 0, "R9", "no extra done", done, 0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(quotient == '0 && remainder == '0, "R10", "outputs in reset",
              {quotient, remainder}, 0);
        check(done == 1'b0 && div_zero == 1'b0 && ready == 1'b1, "R10", "flags in reset",
              {done, div_zero, ready}, 3'b001);
        rst = 1'b0;

        for (int m = 0; m < 2; m++) begin
            // R1 R2 R3 R4 all sign quadrants
            run_op(16'd7, 16'd2, 1, m[0], 1);
            run_op(-16'sd7, 16'd2, 1, m[0], 1);
            run_op(16'd7, -16'sd2, 1, m[0], 1);
            run_op(-16'sd7, -16'sd2, 1, m[0], 1);
            run_op(-16'sd9, 16'd3, 1, m[0], 0);
            run_op(16'd5, 16'd7, 1, m[0], 0);
            run_op(-16'sd5, 16'd7, 1, m[0], 0);
            // R7
            run_op(16'h8000, 16'hFFFF, 1, m[0], 1);
            run_op(16'h8000, 16'h0001, 1, m[0], 0);
            run_op(16'h7FFF, 16'h8000, 1, m[0], 0);
            // R6 zero divisor, both signedness
            run_op(16'hBEEF, 16'h0000, 1, m[0], 1);
            run_op(16'h1234, 16'h0000, 0, m[0], 0);
            // R5 unsigned
            run_op(16'hFFFF, 16'd3, 0, m[0], 0);
            run_op(16'h8000, 16'hFFFF, 0, m[0], 0);
            run_op(16'd0, 16'd5, 0, m[0], 0);
        end

        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            if (i % 4 == 0) rb = W'($urandom_range(0, 9)) - W'(4);
            run_op(ra, rb, $urandom_range(0, 1), $urandom_range(0, 1), (i % 10) == 0);
        end

        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule